// File: doc/BRIEF.md
# Phase-Frequency Detector with Anti-Backlash Overlap

This block compares two edge streams: the divided reference and the divided feedback of a synthesizer loop. It drives `up` and `down` pulses whose widths show how far one stream leads the other in phase and frequency. Both inputs are sampled by a fast system clock. Each one passes through a two-flop synchronizer and a rising-edge detector. Two state bits then form the classic three-state detector. A reference edge sets `up` and a feedback edge sets `down`.

When both state bits are high, they stay high together for a minimum overlap and then clear in the same cycle. This guarantees a pulse on both outputs even when the phases are aligned, which removes the dead zone. The overlap length comes from `int_mode`. Fractional-N operation uses the long overlap of 6 clock cycles and integer-N operation uses the short overlap of 3 clock cycles. Edges that arrive while the pair is being cleared are held and applied afterwards. A lock flag watches how long the pulses last over a run of comparisons.

Top module: `pfd_abl_top`

## Requirements
- R1: While `rst_n` is low and directly after its release, `up`, `down` and `locked` are 0.
- R2: A rising edge on `ref_in` that is first sampled at clock edge t makes `up` high after clock edge t+2. Falling edges and steady levels set nothing.
- R3: A rising edge on `fb_in` that is first sampled at clock edge t makes `down` high after clock edge t+2.
- R4: While exactly one of `up` and `down` is high, further rising edges on the input that set it have no effect. No extra pulse follows the clear.
- R5: With the latched mode at 0 (fractional-N), once both outputs are high they stay high together for exactly 6 cycles. Both then fall on the same edge.
- R6: With the latched mode at 1 (integer-N), the joint high time is exactly 3 cycles.
- R7: `int_mode` is captured only on edges where both outputs are low. A change while a pulse is in progress affects only later comparisons.
- R8: A rising edge on either input whose detection falls inside the joint high time, including its clearing edge, is held. It sets its output on the edge after the clear, which leaves exactly one low cycle.
- R9: Each clear is one comparison. It is good when the longer pulse was high for at most the active overlap plus 2 cycles. `locked` goes high on the clear edge that completes 16 consecutive good comparisons and drops on the clear edge of a bad one.
- R10: Reset discards held edges, the latched mode and the count of good comparisons.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_in | input | 1 | Divided reference stream |
| fb_in | input | 1 | Divided feedback stream |
| int_mode | input | 1 | 0: long overlap (6 cycles), 1: short overlap (3 cycles) |
| up | output | 1 | Pump-up pulse |
| down | output | 1 | Pump-down pulse |
| locked | output | 1 | Consecutive good comparisons reached 16 |

## Verification
The edge-to-output properties look back four cycles at the raw inputs, so they assume both inputs are low through reset and for several cycles after it. The stimulus holds them there. Each input must also be low for at least one sampled cycle between pulses, or no rising edge is seen. The bench drives 2-cycle pulses with gaps, changes inputs only at the falling clock edge, and changes `int_mode` only at chosen points inside a window. This lets the bench place an edge precisely inside an overlap or onto its clearing edge.

// File: rtl/pfd_abl_pkg.sv
package pfd_abl_pkg;

  typedef enum logic {
    MODE_FRAC = 1'b0,
    MODE_INT  = 1'b1
  } pfd_mode_e;

  typedef struct packed {
    logic fb_e;
    logic ref_e;
  } edge_pair_t;

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[SH_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_nxt;
    end
  end

  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

endmodule

// File: rtl/pfd_tristate_core.sv
module pfd_tristate_core
  import pfd_abl_pkg::*;
#(
  parameter int FRAC_DLY = 6,
  parameter int INT_DLY  = 3,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  edge_pair_t       ev,
  input  logic             int_mode,
  output logic             up_o,
  output logic             dn_o,
  output logic             clr_o,
  output logic [CNT_W-1:0] dly_o
);
  logic             up_q, dn_q, up_nxt, dn_nxt;
  logic             pu_q, pd_q, pu_nxt, pd_nxt;
  logic [CNT_W-1:0] ov_q, ov_nxt;
  pfd_mode_e        mode_q, mode_nxt;
  logic             both_hi;

  always_comb begin
    both_hi  = up_q & dn_q;
    dly_o    = (mode_q == MODE_INT) ? CNT_W'(INT_DLY) : CNT_W'(FRAC_DLY);
    clr_o    = both_hi && (ov_q == dly_o - CNT_W'(1));
    mode_nxt = (!up_q && !dn_q) ? pfd_mode_e'(int_mode) : mode_q;
    up_nxt   = up_q;
    dn_nxt   = dn_q;
    pu_nxt   = pu_q;
    pd_nxt   = pd_q;
    ov_nxt   = ov_q;
    if (both_hi) begin
      pu_nxt = pu_q | ev.ref_e;
      pd_nxt = pd_q | ev.fb_e;
      if (clr_o) begin
        up_nxt = 1'b0;
        dn_nxt = 1'b0;
        ov_nxt = '0;
      end else begin
        ov_nxt = ov_q + CNT_W'(1);
      end
    end else begin
      up_nxt = up_q | ev.ref_e | pu_q;
      dn_nxt = dn_q | ev.fb_e  | pd_q;
      pu_nxt = 1'b0;
      pd_nxt = 1'b0;
      ov_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      pu_q   <= 1'b0;
      pd_q   <= 1'b0;
      ov_q   <= '0;
      mode_q <= MODE_FRAC;
    end else begin
      up_q   <= up_nxt;
      dn_q   <= dn_nxt;
      pu_q   <= pu_nxt;
      pd_q   <= pd_nxt;
      ov_q   <= ov_nxt;
      mode_q <= mode_nxt;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int CNT_W      = 3,
  parameter int LEN_W      = 8,
  parameter int LOCK_COUNT = 16,
  parameter int LOCK_SLACK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic             locked_o
);
  localparam int GOOD_W = $clog2(LOCK_COUNT + 1);
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

  logic [LEN_W-1:0]  up_len_q, up_len_nxt, dn_len_q, dn_len_nxt;
  logic [GOOD_W-1:0] good_q, good_nxt;
  logic [LEN_W:0]    longest, limit;

  always_comb begin
    up_len_nxt = up_i ? ((up_len_q == LEN_MAX) ? up_len_q : up_len_q + LEN_W'(1)) : '0;
    dn_len_nxt = dn_i ? ((dn_len_q == LEN_MAX) ? dn_len_q : dn_len_q + LEN_W'(1)) : '0;
    longest    = ((up_len_q > dn_len_q) ? {1'b0, up_len_q} : {1'b0, dn_len_q}) + (LEN_W+1)'(1);
    limit      = (LEN_W+1)'(dly_i) + (LEN_W+1)'(LOCK_SLACK);
    good_nxt   = good_q;
    if (clr_i) begin
      if (longest <= limit) begin
        good_nxt = (good_q == GOOD_W'(LOCK_COUNT)) ? good_q : good_q + GOOD_W'(1);
      end else begin
        good_nxt = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_len_q <= '0;
      dn_len_q <= '0;
      good_q   <= '0;
    end else begin
      up_len_q <= up_len_nxt;
      dn_len_q <= dn_len_nxt;
      good_q   <= good_nxt;
    end
  end

  assign locked_o = (good_q == GOOD_W'(LOCK_COUNT));

endmodule

// File: rtl/pfd_abl_top.sv
module pfd_abl_top
  import pfd_abl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAC_DLY    = 6,
  parameter int INT_DLY     = 3,
  parameter int LEN_W       = 8,
  parameter int LOCK_COUNT  = 16,
  parameter int LOCK_SLACK  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  input  logic int_mode,
  output logic up,
  output logic down,
  output logic locked
);
  localparam int MAX_DLY = (FRAC_DLY > INT_DLY) ? FRAC_DLY : INT_DLY;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);
  localparam int N_IN    = 2;

  logic [N_IN-1:0]  raw_in, raw_rise;
  edge_pair_t       ev;
  logic             clr;
  logic [CNT_W-1:0] dly;

  assign raw_in = {fb_in, ref_in};

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_edge
    pfd_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (raw_in[gi]),
      .rise_o (raw_rise[gi])
    );
  end

  assign ev.ref_e = raw_rise[0];
  assign ev.fb_e  = raw_rise[1];

  pfd_tristate_core #(
    .FRAC_DLY (FRAC_DLY),
    .INT_DLY  (INT_DLY),
    .CNT_W    (CNT_W)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .int_mode (int_mode),
    .up_o     (up),
    .dn_o     (down),
    .clr_o    (clr),
    .dly_o    (dly)
  );

  pfd_lock_det #(
    .CNT_W      (CNT_W),
    .LEN_W      (LEN_W),
    .LOCK_COUNT (LOCK_COUNT),
    .LOCK_SLACK (LOCK_SLACK)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_i     (up),
    .dn_i     (down),
    .clr_i    (clr),
    .dly_i    (dly),
    .locked_o (locked)
  );

endmodule

// File: rtl/pfd_abl_chk.sv
module pfd_abl_chk #(
  parameter int MAX_OV = 6
) (
  input logic clk,
  input logic rst_n,
  input logic ref_in,
  input logic fb_in,
  input logic up,
  input logic down,
  input logic locked
);
  logic [3:0] both_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      both_run <= '0;
    end else if (up && down) begin
      both_run <= (both_run == 4'hF) ? both_run : both_run + 4'd1;
    end else begin
      both_run <= '0;
    end
  end

  AST_OVERLAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    both_run <= 4'(MAX_OV)); // R5

  AST_CLEAR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up) |-> $fell(down)); // R5

  AST_REF_SETS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ref_in, 3) && !$past(ref_in, 4) && !$past(up) && !$past(down)) |-> up); // R2

  AST_FB_SETS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fb_in, 3) && !$past(fb_in, 4) && !$past(up) && !$past(down)) |-> down); // R3

  AST_LOCK_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $fell(down)); // R9

endmodule

bind pfd_abl_top pfd_abl_chk #(.MAX_OV(6)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ref_in (ref_in),
  .fb_in  (fb_in),
  .up     (up),
  .down   (down),
  .locked (locked)
);

// File: tb/pfd_abl_top_tb.sv
module pfd_abl_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic int_mode = 1'b0;
  logic up, down, locked;

  always #10 clk = ~clk;

  pfd_abl_top dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .int_mode(int_mode), .up(up), .down(down), .locked(locked)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int hr[4], hf[4];
  int m_up, m_dn, m_pu, m_pd, m_ov, m_int, m_ulen, m_dlen, m_good;
  int er, ef, dly, clr, longest, nxt_int;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin hr[i] = 0; hf[i] = 0; end
      m_up = 0; m_dn = 0; m_pu = 0; m_pd = 0; m_ov = 0; m_int = 0;
      m_ulen = 0; m_dlen = 0; m_good = 0;
    end else begin
      er = (hr[1] == 1 && hr[2] == 0) ? 1 : 0;
      ef = (hf[1] == 1 && hf[2] == 0) ? 1 : 0;
      for (int i = 3; i > 0; i--) begin hr[i] = hr[i-1]; hf[i] = hf[i-1]; end
      hr[0] = int'(ref_in);
      hf[0] = int'(fb_in);
      dly = (m_int != 0) ? 3 : 6;
      clr = (m_up != 0 && m_dn != 0 && m_ov == dly - 1) ? 1 : 0;
      if (clr != 0) begin
        longest = ((m_ulen > m_dlen) ? m_ulen : m_dlen) + 1;
        if (longest <= dly + 2) m_good = (m_good < 16) ? m_good + 1 : 16;
        else m_good = 0;
      end
      m_ulen = (m_up != 0) ? m_ulen + 1 : 0;
      m_dlen = (m_dn != 0) ? m_dlen + 1 : 0;
      nxt_int = (m_up == 0 && m_dn == 0) ? int'(int_mode) : m_int;
      if (m_up != 0 && m_dn != 0) begin
        if (er != 0) m_pu = 1;
        if (ef != 0) m_pd = 1;
        if (clr != 0) begin m_up = 0; m_dn = 0; m_ov = 0; end
        else m_ov = m_ov + 1;
      end else begin
        if (er != 0 || m_pu != 0) m_up = 1;
        if (ef != 0 || m_pd != 0) m_dn = 1;
        m_pu = 0; m_pd = 0; m_ov = 0;
      end
      m_int = nxt_int;
    end
  end

  // per-cycle comparison and pulse-width tracking
  int run_u = 0, run_d = 0, w_up = 0, w_dn = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R4 R5 R6 R7 R8 up vs model", int'(up), m_up);
      chk("R3 down vs model", int'(down), m_dn);
      chk("R9 locked vs model", int'(locked), (m_good == 16) ? 1 : 0);
      if (up) run_u++; else begin if (run_u > 0) w_up = run_u; run_u = 0; end
      if (down) run_d++; else begin if (run_d > 0) w_dn = run_d; run_d = 0; end
    end
  end

  // one 30-cycle window; pulses 2 cycles long, -1 disables
  task automatic run_win(input int ra, input int rb, input int fa, input int fb2, input int mflip);
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      ref_in = ((ra >= 0 && t >= ra && t < ra + 2) || (rb >= 0 && t >= rb && t < rb + 2));
      fb_in  = ((fa >= 0 && t >= fa && t < fa + 2) || (fb2 >= 0 && t >= fb2 && t < fb2 + 2));
      if (mflip >= 0 && t == mflip) int_mode = 1'b1;
    end
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 up in reset", int'(up), 0);
    chk("R1 down in reset", int'(down), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    chk("R1 locked after reset", int'(locked), 0);
    chk("R1 up after reset", int'(up), 0);

    int_mode = 1'b0;
    run_win(0, -1, 0, -1, -1);
    chk("R5 up width frac", w_up, 6);
    chk("R5 down width frac", w_dn, 6);

    int_mode = 1'b1;
    run_win(0, -1, 0, -1, -1);
    chk("R6 up width int", w_up, 3);
    chk("R6 down width int", w_dn, 3);

    run_win(0, -1, 4, -1, -1);
    chk("R2 up width ref leads 4", w_up, 7);
    chk("R3 down width ref leads 4", w_dn, 3);

    run_win(0, 8, 14, -1, -1);
    chk("R4 up width with repeated ref", w_up, 17);
    chk("R4 no pulse after clear", int'(up), 0);

    int_mode = 1'b0;
    run_win(0, -1, 0, -1, 4);
    chk("R7 down width after mid-pulse switch", w_dn, 6);
    run_win(0, -1, 0, -1, -1);
    chk("R7 new mode on next comparison", w_dn, 3);

    run_win(0, 3, 0, 12, -1);
    chk("R8 held ref edge pulse width", w_up, 11);
    chk("R8 down width", w_dn, 3);

    for (int k = 0; k < 15; k++) run_win(0, -1, 0, -1, -1);
    chk("R9 not locked after 15", int'(locked), 0);
    run_win(0, -1, 0, -1, -1);
    chk("R9 locked after 16", int'(locked), 1);
    run_win(0, -1, 2, -1, -1);
    chk("R9 lead 2 stays locked", int'(locked), 1);
    run_win(0, -1, 3, -1, -1);
    chk("R9 lead 3 drops lock", int'(locked), 0);

    for (int k = 0; k < 16; k++) run_win(0, -1, 0, -1, -1);
    chk("R10 relocked before reset", int'(locked), 1);
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      ref_in = (t < 2) || (t >= 3 && t < 5);
      fb_in  = (t < 2);
    end
    @(negedge clk);
    rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0; int_mode = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    begin
      int seen = 0;
      for (int t = 0; t < 12; t++) begin
        @(negedge clk); #1;
        if (up || down || locked) seen++;
      end
      chk("R10 held edge and lock discarded", seen, 0);
    end

    int_mode = 1'b0;
    run_win(0, -1, 0, -1, -1);
    chk("R10 mode back to long overlap", w_up, 6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule